// File: doc/BRIEF.md
# Serial memory status-register write controller

This block is the device-side command logic of a serial memory that lets a host change its block-protect bits over a four-wire serial link. The host lowers chip select and sends an 8-bit opcode, most significant bit first. Input bits are sampled on rising serial-clock edges. For a status write, one data byte follows the opcode. The command only takes effect if chip select returns high in the short window after the sixteenth rising edge and before any further rising edge. Even then it is refused unless three conditions hold: the write-enable latch is set, no write cycle is running, and the active-low protect pin is high.

An accepted write starts a self-timed internal cycle of `WR_CYCLES` system clocks. The busy flag is set for the whole cycle. At the end of the cycle the two protect bits take their new values and the write-enable latch clears. Three helper commands are provided: write enable, write disable and status read. The status read shifts the register out on falling serial-clock edges, so the host can poll the busy flag during a cycle.

All pins are synchronised into the single system clock, and serial-clock edges are detected in that domain. The serial clock must therefore be several times slower than the system clock.

Top module: `spi_stat_wr_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 and `miso_oe` is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect only on a deselect after exactly 8 bits, and both are ignored while a write cycle runs.
- R3: Opcode 0x05 drives `miso_oe` high from the 8th bit onward. It then presents the status byte MSB first, with a new bit after each falling serial-clock edge. The byte layout is: bits 7..4 zero, bits 3..2 protect field, bit 1 write-enable latch, bit 0 busy flag.
- R4: Opcode 0x01 followed by a data byte, deselected after exactly 16 bits with all conditions met, sets the busy flag for `WR_CYCLES` system clocks. At the end of the cycle the busy flag clears, the protect field loads data bits 3..2, and the write-enable latch clears.
- R5: Data bits 7..4, 1 and 0 of a status write never change the register.
- R6: A status write is refused when the write-enable latch is 0.
- R7: A status write is refused when `wp_n` is low at deselect.
- R8: A status write is refused while a write cycle is in progress, and the running cycle still completes with its own data.
- R9: A status write deselected after fewer or more than 16 bits is aborted.
- R10: `miso_oe` stays low for every command other than a status read.
- R11: The protect field keeps its old value while the busy flag is set and changes only when the cycle ends.
- R12: A refused or aborted status write leaves the write-enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The bench probes the deselect window with frames of 15, 16 and 17 bits. A design that checked for "at least 16 bits" would wrongly commit the 17-bit frame. A design that counted from a stale state would commit the 15-bit frame.

It issues a second status write, and a write disable, while a cycle runs. A design that re-armed the timer would end with the second data value. A design that honoured the disable mid-cycle would show the latch cleared early.

It polls status during the cycle to catch protect bits that update at acceptance instead of at completion. Random data bytes with the unwritable bits set show any leak of those bits into the register.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam int OPC_BITS   = 8;
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = 5;

  typedef struct packed {
    logic [1:0] prot;
    logic       wel;
    logic       wip;
  } stat_t;

  function automatic logic [7:0] stat_byte(stat_t s);
    return {4'b0000, s.prot, s.wel, s.wip};
  endfunction

  function automatic logic wrsr_ok(logic wel, logic wip, logic wp_n);
    return wel & ~wip & wp_n;
  endfunction

  function automatic logic [1:0] prot_field(logic [7:0] d);
    return d[3:2];
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic m1, m2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= RST_VAL[i];
        m2 <= RST_VAL[i];
        prev <= RST_VAL[i];
      end else begin
        m1 <= din[i];
        m2 <= m1;
        prev <= m2;
      end
    end
    assign q[i]    = m2;
    assign rise[i] = m2 & ~prev;
    assign fall[i] = ~m2 & prev;
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_s,
  input  logic       cs_rise,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic [7:0] stat_i,
  output logic       wren_evt,
  output logic       wrdi_evt,
  output logic       wrsr_evt,
  output logic [7:0] wrsr_data,
  output logic       miso,
  output logic       miso_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_OPC = CNT_W'(OPC_BITS);
  localparam logic [CNT_W-1:0] CNT_FRM = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      sh_q;
  logic [7:0]       op_q;
  logic [7:0]       out_q;
  logic             rd_act_q;
  logic [7:0]       next_op;
  logic             opc_edge;

  assign next_op  = {sh_q[6:0], mosi_s};
  assign opc_edge = sck_rise && !cs_n_s && (cnt_q == CNT_OPC - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      op_q     <= '0;
      out_q    <= '0;
      rd_act_q <= 1'b0;
    end else if (cs_n_s) begin
      cnt_q    <= '0;
      rd_act_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh_q <= {sh_q[14:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (opc_edge) begin
        op_q <= next_op;
        if (next_op == OP_RDSR) begin
          rd_act_q <= 1'b1;
          out_q    <= stat_i;
        end
      end
      if (sck_fall && rd_act_q && cnt_q > CNT_OPC) out_q <= {out_q[6:0], 1'b0};
    end
  end

  assign wren_evt  = cs_rise && cnt_q == CNT_OPC && op_q == OP_WREN;
  assign wrdi_evt  = cs_rise && cnt_q == CNT_OPC && op_q == OP_WRDI;
  assign wrsr_evt  = cs_rise && cnt_q == CNT_FRM && op_q == OP_WRSR;
  assign wrsr_data = sh_q[7:0];
  assign miso      = rd_act_q ? out_q[7] : 1'b0;
  assign miso_oe   = rd_act_q && !cs_n_s;

  // R10: output is only driven inside a status read
  assert_oe_only_rdsr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> op_q == OP_RDSR);
  // R9: any deselect restarts the bit count
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> cnt_q == '0);
endmodule

// File: rtl/spi_stat_core.sv
module spi_stat_core
  import spi_stat_pkg::*;
#(
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren_evt,
  input  logic       wrdi_evt,
  input  logic       wrsr_evt,
  input  logic [7:0] wrsr_data,
  input  logic       wp_n_s,
  output logic [7:0] stat_o
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  stat_t         st_q;
  logic [1:0]    pend_q;
  logic [TW-1:0] tmr_q;
  logic          accept;
  logic          cycle_done;

  assign accept     = wrsr_evt && wrsr_ok(st_q.wel, st_q.wip, wp_n_s);
  assign cycle_done = st_q.wip && tmr_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= '0;
      tmr_q  <= '0;
    end else if (st_q.wip) begin
      if (cycle_done) begin
        st_q.wip  <= 1'b0;
        st_q.wel  <= 1'b0;
        st_q.prot <= pend_q;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else if (accept) begin
      st_q.wip <= 1'b1;
      pend_q   <= prot_field(wrsr_data);
      tmr_q    <= TW'(WR_CYCLES - 1);
    end else if (wren_evt) begin
      st_q.wel <= 1'b1;
    end else if (wrdi_evt) begin
      st_q.wel <= 1'b0;
    end
  end

  assign stat_o = stat_byte(st_q);

  // R4: a cycle starts only from a status-write deselect
  assert_wip_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.wip) |-> $past(wrsr_evt));
  // R11: protect field moves only at cycle completion
  assert_prot_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_q.prot) |-> $past(cycle_done));
  // R4: latch is cleared when the cycle ends
  assert_wel_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.wip) |-> !st_q.wel);
  // R6, R7: refused writes start no cycle
  assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_evt && !st_q.wip && (!st_q.wel || !wp_n_s) |=> !st_q.wip);
  // R2: latch commands have no effect during a cycle
  assert_wel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.wip && !cycle_done |=> $stable(st_q.wel));
endmodule

// File: rtl/spi_stat_wr_ctrl.sv
module spi_stat_wr_ctrl
  import spi_stat_pkg::*;
#(
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);
  logic [3:0] pin_s, pin_r, pin_f;
  logic       wren_evt, wrdi_evt, wrsr_evt;
  logic [7:0] wrsr_data, stat;

  // bit order: 3 cs_n, 2 sck, 1 mosi, 0 wp_n
  spi_in_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, mosi, wp_n}),
    .q(pin_s), .rise(pin_r), .fall(pin_f)
  );

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n_s(pin_s[3]), .cs_rise(pin_r[3]),
    .sck_rise(pin_r[2]), .sck_fall(pin_f[2]), .mosi_s(pin_s[1]),
    .stat_i(stat), .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
    .wrsr_evt(wrsr_evt), .wrsr_data(wrsr_data), .miso(miso), .miso_oe(miso_oe)
  );

  spi_stat_core #(.WR_CYCLES(WR_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n), .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
    .wrsr_evt(wrsr_evt), .wrsr_data(wrsr_data), .wp_n_s(pin_s[0]), .stat_o(stat)
  );

  // R1: nothing driven while deselected
  assert_oe_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s[3] |-> !miso_oe);
endmodule

// File: tb/spi_stat_wr_ctrl_tb_top.sv
module spi_stat_wr_ctrl_tb_top;
  localparam int WRC  = 1500;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_stat_wr_ctrl #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic [7:0] model_stat(logic [1:0] bp, logic wel, logic wip);
    logic [7:0] r = 8'h00;
    r[3] = bp[1]; r[2] = bp[0]; r[1] = wel; r[0] = wip;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // sends n bits of 'bits' (LSB-aligned, MSB first); rd = bits seen after the opcode
  task automatic frame(input logic [16:0] bits, input int n,
                       output logic [7:0] rd, output logic oe_early, output logic oe_all);
    rd = 8'h00; oe_early = 1'b0; oe_all = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      wait_clk(HALF);
      if (i < 8) oe_early |= miso_oe;
      else if (i < 16) begin
        rd = {rd[6:0], miso};
        oe_all &= miso_oe;
      end
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic cmd8(logic [7:0] op, string req);
    logic [7:0] rd; logic e, a;
    frame({9'h0, op}, 8, rd, e, a);
    chk(req, e, 1'b0);
  endtask

  task automatic wrsr(logic [7:0] d, int n, string req);
    logic [7:0] rd; logic e, a;
    logic [16:0] b = {1'b0, 8'h01, d};
    if (n == 15) b = {2'b0, 8'h01, d[7:1]};
    if (n == 17) b = {8'h01, d, 1'b0};
    frame(b, n, rd, e, a);
    chk({req, " R10 oe during write"}, e | (a & 1'b0), 1'b0);
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic e, a;
    frame({1'b0, 8'h05, 8'h00}, 16, v, e, a);
    chk("R3 oe low in opcode", e, 1'b0);
    chk("R3 oe high in data", a, 1'b1);
  endtask

  task automatic wait_idle(output logic [7:0] v);
    v = 8'h01;
    for (int k = 0; k < 30 && v[0]; k++) rdsr(v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    logic [1:0] e_bp;
    logic e_wel, wpv, acc;
    int n, r;
    void'($urandom(32'h5A17));
    wait_clk(5);
    chk("R1 oe at reset", miso_oe, 1'b0);
    rst_n = 1'b1;
    wait_clk(5);
    rdsr(v); chk("R1 reset status", v, 8'h00);

    cmd8(8'h06, "R10 wren"); rdsr(v); chk("R2 wren sets", v, 8'h02);
    cmd8(8'h04, "R10 wrdi"); rdsr(v); chk("R2 wrdi clears", v, 8'h00);

    cmd8(8'h06, "R10 wren");
    wrsr(8'hFF, 16, "R4");
    rdsr(v); chk("R11 old bits while busy", v, 8'h03);
    cmd8(8'h04, "R10 wrdi");
    rdsr(v); chk("R2 wrdi ignored when busy", v, 8'h03);
    wrsr(8'h00, 16, "R8");
    rdsr(v); chk("R8 busy still", v, 8'h03);
    wait_idle(v); chk("R4 R5 R8 done", v, 8'h0C);

    wrsr(8'h00, 16, "R6");
    rdsr(v); chk("R6 no wel refused", v, 8'h0C);

    cmd8(8'h06, "R10 wren");
    wp_n = 1'b0;
    wrsr(8'h00, 16, "R7");
    rdsr(v); chk("R7 R12 protect pin refused", v, 8'h0E);
    wp_n = 1'b1;
    wrsr(8'h00, 15, "R9");
    rdsr(v); chk("R9 R12 15 bits aborted", v, 8'h0E);
    wrsr(8'h00, 17, "R9");
    rdsr(v); chk("R9 R12 17 bits aborted", v, 8'h0E);

    e_bp = 2'b11; e_wel = 1'b1;
    for (int it = 0; it < 16; it++) begin
      if ($urandom % 2 == 0) begin cmd8(8'h06, "R10 wren"); e_wel = 1'b1; end
      wpv = ($urandom % 4) != 0;
      r = $urandom % 6;
      n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      d = 8'($urandom);
      wp_n = wpv;
      wrsr(d, n, "R9 random");
      wp_n = 1'b1;
      acc = e_wel && wpv && n == 16;
      rdsr(v);
      if (acc) begin
        chk("R4 R11 random busy", v, model_stat(e_bp, 1'b1, 1'b1));
        wait_idle(v);
        e_bp = d[3:2]; e_wel = 1'b0;
        chk("R4 R5 random done", v, model_stat(e_bp, 1'b0, 1'b0));
      end else begin
        chk("R6 R7 R9 R12 random refused", v, model_stat(e_bp, e_wel, 1'b0));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule